// File: doc/BRIEF.md
# Mailbox Processor Handoff Controller

Two processors share one system and take turns running. One is the requester and the other is the servicer. To ask for an I/O task, the requester first writes a command word and its argument words into a small mailbox, then pulses its handoff strobe. The block halts the requester and starts the servicer. The servicer reads the command, does the work, writes a completion status and pulses its own strobe, which halts it. Control then returns to the requester, which reads the status to decide what to do next.

The block holds the mailbox, the ownership state machine and the status word. Each processor has a write port, a read port, a handoff strobe and a run-enable output. Exactly one run-enable is high at a time, and each switch passes through one cycle in which neither is high. After reset the servicer runs, so it can bring the system up before it first hands control to the requester.

The ownership state machine has four states:
- `OWN_SVC`: the servicer runs.
- `GAP_TO_REQ`: idle cycle on the way to the requester.
- `OWN_REQ`: the requester runs.
- `GAP_TO_SVC`: idle cycle on the way to the servicer.

It has four transitions:
- A servicer strobe moves `OWN_SVC` to `GAP_TO_REQ`.
- `GAP_TO_REQ` moves to `OWN_REQ` unconditionally.
- A requester strobe moves `OWN_REQ` to `GAP_TO_SVC` and clears the status to pending.
- `GAP_TO_SVC` moves to `OWN_SVC` unconditionally.

Top module: `mbox_handoff`

## Requirements
- R1: After reset, `run_svc` is 1 and `run_req` is 0, and every mailbox word reads as 0.
- R2: `run_req` and `run_svc` are never both 1.
- R3: An accepted strobe drives both run-enables to 0 for exactly one cycle. In the following cycle the other processor's run-enable is 1.
- R4: Mailbox addresses are: 0 for status, 1 for command, and 2 upward for the argument words. A write from the running processor to address 1 or higher is readable on both read ports in the next cycle.
- R5: A requester strobe accepted in `OWN_REQ` sets the status word to 0 (pending). The new value is readable from the next cycle.
- R6: A servicer write to address 0 stores the low two bits of the write data as the status. The codes are 0 pending, 1 done, 2 error and 3 unknown command, and the status reads back zero-extended. A servicer strobe, even in the same cycle as that write, returns control to the requester, which then reads this status.
- R7: Writes from a processor whose run-enable is 0 leave every mailbox word unchanged. This includes writes made during the idle cycle.
- R8: Requester writes to address 0 leave the status unchanged.
- R9: A strobe from a processor whose run-enable is 0 does not change ownership. This includes strobes made during the idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Requester write enable |
| req_addr | input | ADDR_W | Requester write address |
| req_wdata | input | DATA_W | Requester write data |
| req_hoff | input | 1 | Requester handoff strobe |
| req_raddr | input | ADDR_W | Requester read address |
| req_rdata | output | DATA_W | Requester read data (combinational) |
| run_req | output | 1 | Requester run-enable |
| svc_we | input | 1 | Servicer write enable |
| svc_addr | input | ADDR_W | Servicer write address |
| svc_wdata | input | DATA_W | Servicer write data |
| svc_hoff | input | 1 | Servicer handoff strobe |
| svc_raddr | input | ADDR_W | Servicer read address |
| svc_rdata | output | DATA_W | Servicer read data (combinational) |
| run_svc | output | 1 | Servicer run-enable |

## Verification
The run-enables are decoded straight from the state register, so a wrong ownership state shows on `run_req`/`run_svc` in the same cycle it is entered. Such faults include a skipped idle cycle, a strobe accepted from the halted side, or a stuck gap state. A mailbox word corrupted by a write that should have been ignored shows on the read ports one cycle after the offending edge. A status that was not cleared on handoff can be seen during the idle cycle itself. A cycle-by-cycle model compares both run-enables and both read ports on every clock, so any divergence is reported within one cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        OWN_SVC    = 2'd0,
        GAP_TO_REQ = 2'd1,
        OWN_REQ    = 2'd2,
        GAP_TO_SVC = 2'd3
    } own_state_e;

    typedef enum logic [1:0] {
        ST_PENDING = 2'd0,
        ST_DONE    = 2'd1,
        ST_ERROR   = 2'd2,
        ST_BADCMD  = 2'd3
    } status_e;

endpackage

// File: rtl/hoff_fsm.sv
module hoff_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_hoff,
    input  logic svc_hoff,
    output logic run_req,
    output logic run_svc,
    output logic req_release
);

    own_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_SVC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_SVC:    if (svc_hoff) state_d = GAP_TO_REQ;
            GAP_TO_REQ: state_d = OWN_REQ;
            OWN_REQ:    if (req_hoff) state_d = GAP_TO_SVC;
            GAP_TO_SVC: state_d = OWN_SVC;
        endcase
    end

    always_comb begin
        run_req     = 1'b0;
        run_svc     = 1'b0;
        req_release = 1'b0;
        unique case (state_q)
            OWN_SVC: run_svc = 1'b1;
            OWN_REQ: begin
                run_req     = 1'b1;
                req_release = req_hoff;
            end
            GAP_TO_REQ, GAP_TO_SVC: ;
        endcase
    end

    // R2
    run_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_req && run_svc));

    // R3
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |=> !run_svc);

    // R3
    svc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_svc |=> !run_req);

    // R3
    single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_req && !run_svc) |=> (run_req || run_svc));

    // R9
    svc_strobe_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && svc_hoff && !req_hoff) |=> run_req);

    // R9
    req_strobe_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_svc && req_hoff && !svc_hoff) |=> run_svc);

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_ARGS = 2,
    parameter int ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              svc_en,
    input  logic              clr_status,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              svc_we,
    input  logic [ADDR_W-1:0] svc_addr,
    input  logic [DATA_W-1:0] svc_wdata,
    input  logic [ADDR_W-1:0] req_raddr,
    input  logic [ADDR_W-1:0] svc_raddr,
    output logic [DATA_W-1:0] req_rdata,
    output logic [DATA_W-1:0] svc_rdata,
    output logic [1:0]        status_q
);

    localparam int BODY_N = NUM_ARGS + 1;
    localparam logic [ADDR_W-1:0] STAT_SLOT = '0;

    logic [DATA_W-1:0] body_q [BODY_N];
    logic              req_wr_ok, svc_wr_ok;

    assign req_wr_ok = req_en && req_we;
    assign svc_wr_ok = svc_en && svc_we;

    generate
        for (genvar i = 0; i < BODY_N; i++) begin : g_word
            localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(i + 1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    body_q[i] <= '0;
                else if (svc_wr_ok && svc_addr == SLOT)
                    body_q[i] <= svc_wdata;
                else if (req_wr_ok && req_addr == SLOT)
                    body_q[i] <= req_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_q <= ST_PENDING;
        else if (clr_status)
            status_q <= ST_PENDING;
        else if (svc_wr_ok && svc_addr == STAT_SLOT)
            status_q <= svc_wdata[1:0];
    end

    always_comb begin
        req_rdata = '0;
        svc_rdata = '0;
        if (req_raddr == STAT_SLOT) req_rdata = {{(DATA_W-2){1'b0}}, status_q};
        if (svc_raddr == STAT_SLOT) svc_rdata = {{(DATA_W-2){1'b0}}, status_q};
        for (int k = 0; k < BODY_N; k++) begin
            if (req_raddr == ADDR_W'(k + 1)) req_rdata = body_q[k];
            if (svc_raddr == ADDR_W'(k + 1)) svc_rdata = body_q[k];
        end
    end

    logic [BODY_N*DATA_W-1:0] body_flat;
    always_comb begin
        for (int k = 0; k < BODY_N; k++)
            body_flat[k*DATA_W +: DATA_W] = body_q[k];
    end

    // R7
    halted_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_en && !svc_en) |=> $stable(body_flat));

    // R7
    halted_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_en && !svc_en) |=> $stable(status_q));

    // R8
    req_status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && !clr_status) |=> $stable(status_q));

endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff
    import mbox_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_ARGS = 2,
    localparam int ADDR_W  = $clog2(NUM_ARGS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hoff,
    input  logic [ADDR_W-1:0] req_raddr,
    output logic [DATA_W-1:0] req_rdata,
    output logic              run_req,
    input  logic              svc_we,
    input  logic [ADDR_W-1:0] svc_addr,
    input  logic [DATA_W-1:0] svc_wdata,
    input  logic              svc_hoff,
    input  logic [ADDR_W-1:0] svc_raddr,
    output logic [DATA_W-1:0] svc_rdata,
    output logic              run_svc
);

    logic       req_release;
    logic [1:0] status_q;

    hoff_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_hoff    (req_hoff),
        .svc_hoff    (svc_hoff),
        .run_req     (run_req),
        .run_svc     (run_svc),
        .req_release (req_release)
    );

    mbox_regs #(
        .DATA_W   (DATA_W),
        .NUM_ARGS (NUM_ARGS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_en     (run_req),
        .svc_en     (run_svc),
        .clr_status (req_release),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .svc_we     (svc_we),
        .svc_addr   (svc_addr),
        .svc_wdata  (svc_wdata),
        .req_raddr  (req_raddr),
        .svc_raddr  (svc_raddr),
        .req_rdata  (req_rdata),
        .svc_rdata  (svc_rdata),
        .status_q   (status_q)
    );

    // R5
    pending_on_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && req_hoff) |=> (status_q == ST_PENDING));

endmodule

// File: tb/mbox_handoff_tb.sv
`timescale 1ns/10ps
module mbox_handoff_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_we = 1'b0, svc_we = 1'b0, req_hoff = 1'b0, svc_hoff = 1'b0;
    logic [1:0] req_addr = '0, svc_addr = '0, req_raddr = '0, svc_raddr = '0;
    logic [7:0] req_wdata = '0, svc_wdata = '0;
    logic [7:0] req_rdata, svc_rdata;
    logic       run_req, run_svc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mbox_handoff u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_hoff(req_hoff), .req_raddr(req_raddr), .req_rdata(req_rdata),
        .run_req(run_req),
        .svc_we(svc_we), .svc_addr(svc_addr), .svc_wdata(svc_wdata),
        .svc_hoff(svc_hoff), .svc_raddr(svc_raddr), .svc_rdata(svc_rdata),
        .run_svc(run_svc)
    );

    // Behavioural reference: 0 servicer runs, 1 gap, 2 requester runs, 3 gap
    int         m_own;
    logic [7:0] m_mb [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = 0;
            for (int i = 0; i < 4; i++) m_mb[i] = 8'h00;
        end else begin
            case (m_own)
                0: begin
                    if (svc_we) begin
                        if (svc_addr == 2'd0) m_mb[0] = {6'b0, svc_wdata[1:0]};
                        else                  m_mb[svc_addr] = svc_wdata;
                    end
                    if (svc_hoff) m_own = 1;
                end
                1: m_own = 2;
                2: begin
                    if (req_we && req_addr != 2'd0) m_mb[req_addr] = req_wdata;
                    if (req_hoff) begin
                        m_mb[0] = 8'h00;
                        m_own = 3;
                    end
                end
                default: m_own = 0;
            endcase
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_we = 1'b0; svc_we = 1'b0; req_hoff = 1'b0; svc_hoff = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek_req(input logic [1:0] a, output logic [7:0] d);
        req_raddr = a;
        #0.1;
        d = req_rdata;
    endtask

    task automatic peek_svc(input logic [1:0] a, output logic [7:0] d);
        svc_raddr = a;
        #0.1;
        d = svc_rdata;
    endtask

    task automatic compare_all();
        chk("R2", "run_req vs model", 32'(run_req), 32'(m_own == 2));
        chk("R2", "run_svc vs model", 32'(run_svc), 32'(m_own == 0));
        chk("R4", "req_rdata vs model", 32'(req_rdata), 32'(m_mb[req_raddr]));
        chk("R4", "svc_rdata vs model", 32'(svc_rdata), 32'(m_mb[svc_raddr]));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "run_svc after reset", 32'(run_svc), 32'd1);
        chk("R1", "run_req after reset", 32'(run_req), 32'd0);
        for (int a = 0; a < 4; a++) begin
            peek_req(2'(a), d);
            chk("R1", "mailbox word after reset", 32'(d), 32'd0);
        end

        // R7 requester write while halted
        req_we = 1'b1; req_addr = 2'd1; req_wdata = 8'hAA;
        tick(); idle_inputs();
        peek_req(2'd1, d);
        chk("R7", "halted requester write", 32'(d), 32'd0);

        // R9 requester strobe while halted
        req_hoff = 1'b1;
        tick(); idle_inputs();
        chk("R9", "run_svc after halted req strobe", 32'(run_svc), 32'd1);
        tick();
        chk("R9", "run_svc one cycle later", 32'(run_svc), 32'd1);

        // R3 servicer hands over; gap cycle
        svc_hoff = 1'b1;
        tick(); idle_inputs();
        chk("R3", "run_svc in gap", 32'(run_svc), 32'd0);
        chk("R3", "run_req in gap", 32'(run_req), 32'd0);
        // R7/R9 writes and strobe during the gap
        req_we = 1'b1; req_addr = 2'd1; req_wdata = 8'h77; req_hoff = 1'b1;
        svc_we = 1'b1; svc_addr = 2'd2; svc_wdata = 8'h33;
        tick(); idle_inputs();
        chk("R3", "run_req after gap", 32'(run_req), 32'd1);
        peek_req(2'd1, d);
        chk("R7", "gap requester write", 32'(d), 32'd0);
        peek_req(2'd2, d);
        chk("R7", "gap servicer write", 32'(d), 32'd0);
        tick();
        chk("R9", "gap strobe ignored", 32'(run_req), 32'd1);

        // R4 requester fills the mailbox, R8 status write
        req_we = 1'b1; req_addr = 2'd1; req_wdata = 8'h5A;
        tick();
        req_addr = 2'd2; req_wdata = 8'h11;
        tick();
        req_addr = 2'd0; req_wdata = 8'h03;
        tick(); idle_inputs();
        peek_req(2'd1, d);
        chk("R4", "command via requester port", 32'(d), 32'h5A);
        peek_svc(2'd2, d);
        chk("R4", "argument via servicer port", 32'(d), 32'h11);
        peek_req(2'd0, d);
        chk("R8", "status after requester write", 32'(d), 32'd0);

        // R7 servicer write while halted
        svc_we = 1'b1; svc_addr = 2'd2; svc_wdata = 8'hFF;
        tick(); idle_inputs();
        peek_req(2'd2, d);
        chk("R7", "halted servicer write", 32'(d), 32'h11);

        // R9 servicer strobe while halted
        svc_hoff = 1'b1;
        tick(); idle_inputs();
        chk("R9", "run_req after halted svc strobe", 32'(run_req), 32'd1);

        // R5 handoff to servicer
        req_hoff = 1'b1;
        tick(); idle_inputs();
        chk("R3", "run_req in gap to servicer", 32'(run_req), 32'd0);
        chk("R3", "run_svc in gap to servicer", 32'(run_svc), 32'd0);
        tick();
        chk("R3", "run_svc after gap", 32'(run_svc), 32'd1);
        peek_svc(2'd1, d);
        chk("R4", "servicer sees command", 32'(d), 32'h5A);
        peek_svc(2'd0, d);
        chk("R5", "status pending after handoff", 32'(d), 32'd0);

        // R6 servicer posts error (code 2) using only low bits of 0xFE
        svc_we = 1'b1; svc_addr = 2'd0; svc_wdata = 8'hFE;
        tick(); idle_inputs();
        peek_svc(2'd0, d);
        chk("R6", "status error code", 32'(d), 32'd2);
        svc_hoff = 1'b1;
        tick(); idle_inputs();
        tick();
        chk("R6", "requester resumes", 32'(run_req), 32'd1);
        peek_req(2'd0, d);
        chk("R6", "requester reads error", 32'(d), 32'd2);

        // R5 status cleared again, visible in the gap cycle
        req_hoff = 1'b1;
        tick(); idle_inputs();
        peek_req(2'd0, d);
        chk("R5", "status cleared on second handoff", 32'(d), 32'd0);
        tick();
        chk("R3", "servicer runs again", 32'(run_svc), 32'd1);

        // R6 unknown command code, then done with strobe in the same cycle
        svc_we = 1'b1; svc_addr = 2'd0; svc_wdata = 8'h03;
        tick(); idle_inputs();
        peek_svc(2'd0, d);
        chk("R6", "status unknown command code", 32'(d), 32'd3);
        svc_we = 1'b1; svc_addr = 2'd0; svc_wdata = 8'h01; svc_hoff = 1'b1;
        tick(); idle_inputs();
        tick();
        chk("R6", "requester resumes after done", 32'(run_req), 32'd1);
        peek_req(2'd0, d);
        chk("R6", "status done code", 32'(d), 32'd1);

        // Mixed traffic compared with the model every cycle (R2, R4)
        @(negedge clk);
        for (int n = 0; n < 4000; n++) begin
            compare_all();
            req_we    = ($urandom % 3) == 0;
            svc_we    = ($urandom % 3) == 0;
            req_hoff  = ($urandom % 6) == 0;
            svc_hoff  = ($urandom % 6) == 0;
            req_addr  = 2'($urandom % 4);
            svc_addr  = 2'($urandom % 4);
            req_wdata = 8'($urandom);
            svc_wdata = 8'($urandom);
            req_raddr = 2'($urandom % 4);
            svc_raddr = 2'($urandom % 4);
            @(negedge clk);
        end
        compare_all();
        finish_run();
    end

endmodule